// File: doc/BRIEF.md
# Transmit DMA Burst Launch Gate

This block decides when a transmit DMA channel may start a host-bus read burst that moves packet data into its transmit queue. It tracks the current packet buffer (start address, bytes still to fetch, and whether the buffer ends a packet) and the free space of the transmit queue, which is modelled as a byte counter. Each cycle it forms a launch threshold: the smaller of the programmed burst size and the bytes still left in the buffer. A burst starts only when the queue can absorb that many bytes, so a short tail or a packet end is never held back waiting for room for a full burst.

When it launches, the block raises a request carrying the start address, the byte count and the beat count. It holds that request until the bus side acknowledges completion, and allows only one request to be outstanding. On launch, the buffer address advances, the remaining count drops, and the queue free space drops by the bytes moved. The queue returns space through a credit strobe. From the same programmed burst length, the block also derives the beat count for a 16-byte descriptor fetch.

The bus width is a parameter. The programmed burst length (in beats) is an input, and a value of zero counts as one beat.

Top module: `tx_burst_gate`

## Requirements
- R1: After reset, no request is pending, the buffer is empty, and the reported free space equals the QUEUE_BYTES parameter.
- R2: A request is raised only when the buffer has bytes left, no request is pending, and the free space is at least min(burst bytes, bytes left). Burst bytes are the effective burst length times BUS_W/8.
- R3: The request's byte count equals that minimum. Its beat count is the byte count divided by BUS_W/8, rounded up. A programmed burst length of 0 is treated as 1 beat.
- R4: The first request after a buffer load carries the loaded start address. Each later request from the same buffer starts at the previous request's address plus its byte count.
- R5: The last-burst flag of a request is 1 exactly when the buffer was loaded with its end-of-packet input at 1 and the request consumes all remaining bytes.
- R6: A pending request keeps its address, beats and bytes stable until the cycle in which the completion strobe is seen. The valid output falls after that edge, and a new request can be raised no earlier than the edge that follows.
- R7: On the edge where a request is raised, the free space drops by its byte count. On any edge where the credit strobe is high, the free space rises by the credited bytes. Both can happen on the same edge.
- R8: A buffer load strobe is ignored while the current buffer still has bytes left; later requests continue the old buffer's addresses.
- R9: The descriptor beat count output equals max(1, min(effective burst length, 128/BUS_W)). With the default 64-bit bus, this is 1 when the burst length is 0 or 1, and 2 otherwise.
- R10: A completion strobe with no pending request has no effect; a later request still waits for its own completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| pbl | input | PBL_W | Programmed burst length in beats (0 treated as 1) |
| bufLoad | input | 1 | Strobe: load a new packet buffer |
| bufAddr | input | ADDR_W | Start address of the buffer being loaded |
| bufLen | input | LEN_W | Byte length of the buffer being loaded |
| bufEop | input | 1 | The buffer being loaded ends a packet |
| qRelease | input | 1 | Strobe: the queue returns free space |
| qRelBytes | input | CNT_W | Bytes returned with qRelease |
| reqDone | input | 1 | Completion of the pending request |
| reqValid | output | 1 | A burst request is pending |
| reqAddr | output | ADDR_W | Start address of the pending request |
| reqBeats | output | PBL_W | Beat count of the pending request |
| reqBytes | output | PBL_W+log2(BUS_W/8) | Byte count of the pending request |
| reqLast | output | 1 | The pending request ends the packet |
| freeBytes | output | CNT_W | Current transmit queue free space |
| descBeats | output | PBL_W | Beat count for a 16-byte descriptor fetch |

## Verification
The bench drives the queue close to full with long bursts so that the remaining room falls below the threshold. A design that compared free space against the full burst, or against the bytes left alone, would launch into a full queue or stall a short tail. It uses a zero burst length and tails that are not a multiple of the bus width, which catch beat-count rounding that truncates or treats zero as zero beats. It sends load strobes and completion strobes at the wrong moments. A design that let them through would overwrite a buffer in flight or drop a request before its real completion. Credits that land on the same edge as a launch expose a free-space counter that loses one of the two updates.

// File: rtl/tx_burst_gate_pkg.sv
package tx_burst_gate_pkg;
  // Strobes from control to datapath, valid for one cycle each.
  typedef struct packed {
    logic issue;   // launch a burst this edge
    logic load;    // accept a new buffer this edge
    logic credit;  // queue returns space this edge
    logic retire;  // pending request completes this edge
  } gateCtl_t;
endpackage

// File: rtl/tx_burst_gate_ctl.sv
module tx_burst_gate_ctl
  import tx_burst_gate_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     canLaunch,
  input  logic     bufEmpty,
  input  logic     bufLoad,
  input  logic     qRelease,
  input  logic     reqDone,
  output gateCtl_t ctl,
  output logic     reqValid
);

  logic validQ;

  always_comb begin
    ctl.issue  = canLaunch && !validQ;
    ctl.load   = bufLoad && bufEmpty;
    ctl.credit = qRelease;
    ctl.retire = validQ && reqDone;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      validQ <= 1'b0;
    end else if (ctl.retire) begin
      validQ <= 1'b0;
    end else if (ctl.issue) begin
      validQ <= 1'b1;
    end
  end

  assign reqValid = validQ;

  // R6: a pending request stays up until its completion is seen
  a_r6_hold_until_done: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && !reqDone |=> reqValid);

  // R10: a completion with nothing pending and nothing launchable leaves the channel idle
  a_r10_idle_done: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid && reqDone && !canLaunch |=> !reqValid);

  // R8: a load is never accepted while a buffer is still draining
  a_r8_no_overwrite: assert property (@(posedge clk) disable iff (!rstN)
    !bufEmpty |-> !ctl.load);

endmodule

// File: rtl/tx_burst_gate_dp.sv
module tx_burst_gate_dp
  import tx_burst_gate_pkg::*;
#(
  parameter int BUS_W       = 64,
  parameter int PBL_W       = 6,
  parameter int LEN_W       = 14,
  parameter int ADDR_W      = 32,
  parameter int QUEUE_BYTES = 2048,
  localparam int BUS_BYTES  = BUS_W / 8,
  localparam int BUS_LG     = $clog2(BUS_BYTES),
  localparam int CNT_W      = $clog2(QUEUE_BYTES + 1),
  localparam int BURST_W    = PBL_W + BUS_LG
) (
  input  logic               clk,
  input  logic               rstN,
  input  gateCtl_t           ctl,
  input  logic               reqValid,
  input  logic               reqDone,
  input  logic [PBL_W-1:0]   pbl,
  input  logic [ADDR_W-1:0]  bufAddr,
  input  logic [LEN_W-1:0]   bufLen,
  input  logic               bufEop,
  input  logic [CNT_W-1:0]   qRelBytes,
  output logic               canLaunch,
  output logic               bufEmpty,
  output logic [ADDR_W-1:0]  reqAddr,
  output logic [PBL_W-1:0]   reqBeats,
  output logic [BURST_W-1:0] reqBytes,
  output logic               reqLast,
  output logic [CNT_W-1:0]   freeBytes,
  output logic [PBL_W-1:0]   descBeats
);

  localparam int W1       = (BURST_W > LEN_W) ? BURST_W : LEN_W;
  localparam int CMP_W    = ((W1 > CNT_W) ? W1 : CNT_W) + 1;
  localparam int DESC_RAW = 128 / BUS_W;

  logic [LEN_W-1:0]   remQ;
  logic [ADDR_W-1:0]  addrQ;
  logic               eopQ;
  logic [CNT_W-1:0]   freeQ;
  logic [ADDR_W-1:0]  reqAddrQ;
  logic [PBL_W-1:0]   reqBeatsQ;
  logic [BURST_W-1:0] reqBytesQ;
  logic               reqLastQ;

  logic [PBL_W-1:0]   pblEff;
  logic [CMP_W-1:0]   burstBytes;
  logic [CMP_W-1:0]   remWide;
  logic [CMP_W-1:0]   thr;
  logic [CMP_W-1:0]   beatsWide;
  logic [CMP_W-1:0]   freeNext;

  // Effective burst length: a zero setting counts as one beat.
  assign pblEff     = (pbl == '0) ? PBL_W'(1) : pbl;
  assign burstBytes = CMP_W'(pblEff) << BUS_LG;
  assign remWide    = CMP_W'(remQ);
  assign thr        = (remWide < burstBytes) ? remWide : burstBytes;

  generate
    if (BUS_LG == 0) begin : g_byteBus
      assign beatsWide = thr;
    end else begin : g_wideBus
      assign beatsWide = (thr + CMP_W'(BUS_BYTES - 1)) >> BUS_LG;
    end
  endgenerate

  generate
    if (DESC_RAW <= 1) begin : g_descOne
      assign descBeats = PBL_W'(1);
    end else begin : g_descCap
      assign descBeats = (CMP_W'(pblEff) < CMP_W'(DESC_RAW)) ? pblEff : PBL_W'(DESC_RAW);
    end
  endgenerate

  assign bufEmpty  = (remQ == '0);
  assign canLaunch = !bufEmpty && (CMP_W'(freeQ) >= thr);

  always_comb begin
    freeNext = CMP_W'(freeQ);
    if (ctl.issue)  freeNext = freeNext - thr;
    if (ctl.credit) freeNext = freeNext + CMP_W'(qRelBytes);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      remQ      <= '0;
      addrQ     <= '0;
      eopQ      <= 1'b0;
      freeQ     <= CNT_W'(QUEUE_BYTES);
      reqAddrQ  <= '0;
      reqBeatsQ <= '0;
      reqBytesQ <= '0;
      reqLastQ  <= 1'b0;
    end else begin
      freeQ <= CNT_W'(freeNext);
      if (ctl.load) begin
        remQ  <= bufLen;
        addrQ <= bufAddr;
        eopQ  <= bufEop;
      end else if (ctl.issue) begin
        remQ      <= remQ - LEN_W'(thr);
        addrQ     <= addrQ + ADDR_W'(thr);
        reqAddrQ  <= addrQ;
        reqBeatsQ <= PBL_W'(beatsWide);
        reqBytesQ <= BURST_W'(thr);
        reqLastQ  <= eopQ && (thr == remWide);
      end
    end
  end

  assign reqAddr   = reqAddrQ;
  assign reqBeats  = reqBeatsQ;
  assign reqBytes  = reqBytesQ;
  assign reqLast   = reqLastQ;
  assign freeBytes = freeQ;

  // R2: a launched burst always fits in the space reported before launch
  a_r2_fits_queue: assert property (@(posedge clk) disable iff (!rstN)
    ctl.issue |=> (CMP_W'(reqBytesQ) <= CMP_W'($past(freeQ))));

  // R3: beats cover the bytes with less than one beat to spare
  a_r3_beats_cover: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |-> (reqBeatsQ != '0)
              && ((CMP_W'(reqBeatsQ) << BUS_LG) >= CMP_W'(reqBytesQ))
              && (((CMP_W'(reqBeatsQ) - 1) << BUS_LG) < CMP_W'(reqBytesQ)));

  // R4: the buffer pointer sits just past the burst that was launched
  a_r4_addr_advance: assert property (@(posedge clk) disable iff (!rstN)
    ctl.issue |=> (addrQ == reqAddrQ + ADDR_W'(reqBytesQ)));

  // R6: request fields are frozen while it waits for completion
  a_r6_fields_stable: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && !reqDone |=> $stable(reqAddrQ) && $stable(reqBeatsQ) && $stable(reqBytesQ));

  // R7: free space never exceeds the queue size
  a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rstN)
    CMP_W'(freeQ) <= CMP_W'(QUEUE_BYTES));

  // R9: descriptor burst is at least one beat and never exceeds the burst length
  a_r9_desc_range: assert property (@(posedge clk) disable iff (!rstN)
    (descBeats != '0) && (descBeats <= pblEff));

endmodule

// File: rtl/tx_burst_gate.sv
module tx_burst_gate
  import tx_burst_gate_pkg::*;
#(
  parameter int BUS_W       = 64,
  parameter int PBL_W       = 6,
  parameter int LEN_W       = 14,
  parameter int ADDR_W      = 32,
  parameter int QUEUE_BYTES = 2048,
  localparam int BUS_LG     = $clog2(BUS_W / 8),
  localparam int CNT_W      = $clog2(QUEUE_BYTES + 1),
  localparam int BURST_W    = PBL_W + BUS_LG
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [PBL_W-1:0]   pbl,
  input  logic               bufLoad,
  input  logic [ADDR_W-1:0]  bufAddr,
  input  logic [LEN_W-1:0]   bufLen,
  input  logic               bufEop,
  input  logic               qRelease,
  input  logic [CNT_W-1:0]   qRelBytes,
  input  logic               reqDone,
  output logic               reqValid,
  output logic [ADDR_W-1:0]  reqAddr,
  output logic [PBL_W-1:0]   reqBeats,
  output logic [BURST_W-1:0] reqBytes,
  output logic               reqLast,
  output logic [CNT_W-1:0]   freeBytes,
  output logic [PBL_W-1:0]   descBeats
);

  gateCtl_t ctl;
  logic     canLaunch;
  logic     bufEmpty;

  tx_burst_gate_ctl u_ctl (
    .clk       (clk),
    .rstN      (rstN),
    .canLaunch (canLaunch),
    .bufEmpty  (bufEmpty),
    .bufLoad   (bufLoad),
    .qRelease  (qRelease),
    .reqDone   (reqDone),
    .ctl       (ctl),
    .reqValid  (reqValid)
  );

  tx_burst_gate_dp #(
    .BUS_W       (BUS_W),
    .PBL_W       (PBL_W),
    .LEN_W       (LEN_W),
    .ADDR_W      (ADDR_W),
    .QUEUE_BYTES (QUEUE_BYTES)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .reqValid  (reqValid),
    .reqDone   (reqDone),
    .pbl       (pbl),
    .bufAddr   (bufAddr),
    .bufLen    (bufLen),
    .bufEop    (bufEop),
    .qRelBytes (qRelBytes),
    .canLaunch (canLaunch),
    .bufEmpty  (bufEmpty),
    .reqAddr   (reqAddr),
    .reqBeats  (reqBeats),
    .reqBytes  (reqBytes),
    .reqLast   (reqLast),
    .freeBytes (freeBytes),
    .descBeats (descBeats)
  );

endmodule

// File: tb/tx_burst_gate_tb.sv
module tx_burst_gate_tb;
  localparam int BUS_W   = 64;
  localparam int PBL_W   = 6;
  localparam int LEN_W   = 14;
  localparam int ADDR_W  = 32;
  localparam int QBYTES  = 2048;
  localparam int BB      = BUS_W / 8;
  localparam int CNT_W   = $clog2(QBYTES + 1);
  localparam int BURST_W = PBL_W + $clog2(BB);

  logic               clk = 1'b0;
  logic               rstN = 1'b0;
  logic [PBL_W-1:0]   pbl = '0;
  logic               bufLoad = 1'b0;
  logic [ADDR_W-1:0]  bufAddr = '0;
  logic [LEN_W-1:0]   bufLen = '0;
  logic               bufEop = 1'b0;
  logic               qRelease = 1'b0;
  logic [CNT_W-1:0]   qRelBytes = '0;
  logic               reqDone = 1'b0;
  logic               reqValid;
  logic [ADDR_W-1:0]  reqAddr;
  logic [PBL_W-1:0]   reqBeats;
  logic [BURST_W-1:0] reqBytes;
  logic               reqLast;
  logic [CNT_W-1:0]   freeBytes;
  logic [PBL_W-1:0]   descBeats;

  tx_burst_gate #(.BUS_W(BUS_W), .PBL_W(PBL_W), .LEN_W(LEN_W), .ADDR_W(ADDR_W),
                  .QUEUE_BYTES(QBYTES)) u_dut (
    .clk(clk), .rstN(rstN), .pbl(pbl), .bufLoad(bufLoad), .bufAddr(bufAddr),
    .bufLen(bufLen), .bufEop(bufEop), .qRelease(qRelease), .qRelBytes(qRelBytes),
    .reqDone(reqDone), .reqValid(reqValid), .reqAddr(reqAddr), .reqBeats(reqBeats),
    .reqBytes(reqBytes), .reqLast(reqLast), .freeBytes(freeBytes), .descBeats(descBeats)
  );

  always #2 clk = ~clk;  // 250 MHz

  int nChecks = 0;
  int nErrors = 0;
  int cyc = 0;
  bit finished = 1'b0;

  // Reference model state (values after the most recent edge)
  bit      mValid;
  longint  mReqAddr, mReqBeats, mReqBytes;
  bit      mReqLast;
  longint  mRem, mAddr, mFree;
  bit      mEop;

  function automatic longint effPbl(input longint p);
    return (p == 0) ? 1 : p;
  endfunction

  function automatic longint launchBytes(input longint p, input longint rem);
    longint b = effPbl(p) * BB;
    return (rem < b) ? rem : b;
  endfunction

  function automatic longint expDesc(input longint p);
    longint cap = 128 / BUS_W;
    longint v = (effPbl(p) < cap) ? effPbl(p) : cap;
    return (v < 1) ? 1 : v;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nErrors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000 && !finished) begin
      nErrors++;
      nChecks++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
      summary();
      $finish;
    end
  end

  // Advance the model with the inputs currently driven
  task automatic modelStep();
    longint thr = launchBytes(pbl, mRem);
    bit issue = (mRem != 0) && (mFree >= thr) && !mValid;
    longint oldRem = mRem;
    if (mValid && reqDone) mValid = 1'b0;
    if (issue) begin
      mValid    = 1'b1;
      mReqAddr  = mAddr;
      mReqBytes = thr;
      mReqBeats = (thr + BB - 1) / BB;
      mReqLast  = mEop && (thr == mRem);
      mRem      = mRem - thr;
      mAddr     = (mAddr + thr) & 64'hFFFF_FFFF;
    end
    mFree = mFree - (issue ? thr : 0) + (qRelease ? longint'(qRelBytes) : 0);
    if (bufLoad && oldRem == 0) begin
      mRem  = bufLen;
      mAddr = bufAddr;
      mEop  = bufEop;
    end
  endtask

  task automatic compareAll();
    chk(reqValid == mValid, "R2", "reqValid", reqValid, mValid);
    if (mValid && reqValid) begin
      chk(reqAddr == mReqAddr[ADDR_W-1:0], "R4", "reqAddr", reqAddr, mReqAddr);
      chk(reqBytes == mReqBytes, "R3", "reqBytes", reqBytes, mReqBytes);
      chk(reqBeats == mReqBeats, "R3", "reqBeats", reqBeats, mReqBeats);
      chk(reqLast == mReqLast, "R5", "reqLast", reqLast, mReqLast);
    end
    chk(freeBytes == mFree, "R7", "freeBytes", freeBytes, mFree);
    chk(descBeats == expDesc(pbl), "R9", "descBeats", descBeats, expDesc(pbl));
  endtask

  task automatic tick();
    modelStep();
    @(posedge clk);
    @(negedge clk);
    compareAll();
  endtask

  task automatic clearPulses();
    bufLoad  = 1'b0;
    qRelease = 1'b0;
    reqDone  = 1'b0;
  endtask

  task automatic waitReq();
    for (int i = 0; i < 30 && !reqValid; i++) tick();
  endtask

  task automatic loadBuf(input longint a, input longint len, input bit eop);
    bufLoad = 1'b1; bufAddr = ADDR_W'(a); bufLen = LEN_W'(len); bufEop = eop;
    tick();
    bufLoad = 1'b0;
  endtask

  task automatic completeReq();
    reqDone = 1'b1;
    tick();
    reqDone = 1'b0;
  endtask

  task automatic refill();
    longint used = QBYTES - mFree;
    if (used > 0) begin
      qRelease = 1'b1; qRelBytes = CNT_W'(used);
      tick();
      qRelease = 1'b0;
    end
  endtask

  initial begin
    void'($urandom(32'd20240719));
    mValid = 0; mReqAddr = 0; mReqBeats = 0; mReqBytes = 0; mReqLast = 0;
    mRem = 0; mAddr = 0; mFree = QBYTES; mEop = 0;

    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    // R1: reset state
    chk(reqValid == 1'b0, "R1", "reqValid after reset", reqValid, 0);
    chk(freeBytes == QBYTES, "R1", "freeBytes after reset", freeBytes, QBYTES);
    tick();
    chk(reqValid == 1'b0, "R1", "no request with empty buffer", reqValid, 0);

    // R8: buffer of 40 bytes with 16-byte bursts; a second load mid-buffer is ignored
    pbl = 6'd2;
    loadBuf(32'h1000, 40, 1'b1);
    waitReq();
    chk(reqAddr == 32'h1000, "R4", "first burst address", reqAddr, 32'h1000);
    loadBuf(32'h9000, 8, 1'b0);
    completeReq();
    waitReq();
    chk(reqAddr == 32'h1010, "R8", "ignored load keeps old buffer", reqAddr, 32'h1010);
    completeReq();
    waitReq();
    chk(reqBytes == 8 && reqLast == 1'b1, "R5", "packet tail bytes/last",
        {reqLast, 16'(reqBytes)}, {1'b1, 16'd8});
    completeReq();
    tick();

    // R10: completion while idle is ignored; R3: zero burst length is one beat
    reqDone = 1'b1; tick(); tick(); reqDone = 1'b0;
    pbl = 6'd0;
    loadBuf(32'h2004, 24, 1'b0);
    waitReq();
    chk(reqBeats == 1 && reqBytes == 8, "R3", "pbl zero gives one beat", reqBeats, 1);
    repeat (3) tick();
    chk(reqValid == 1'b1, "R10", "request held despite earlier idle done", reqValid, 1);
    completeReq();
    waitReq(); completeReq();
    waitReq();
    chk(reqLast == 1'b0, "R5", "no last without end of packet", reqLast, 0);
    completeReq();
    tick();

    // R2: fill the queue with long bursts until the room drops below the threshold
    refill();
    pbl = 6'd63;
    loadBuf(32'h0, 3000, 1'b1);
    for (int i = 0; i < 40; i++) begin
      reqDone = reqValid;
      tick();
    end
    reqDone = 1'b0;
    tick();
    chk(reqValid == 1'b0, "R2", "blocked when queue room below burst", reqValid, 0);
    chk(freeBytes == 32, "R7", "free after four full bursts", freeBytes, 32);
    refill();

    // Random phase
    for (int i = 0; i < 5000; i++) begin
      if ($urandom_range(99) < 5) pbl = PBL_W'($urandom_range(63));
      bufLoad = ($urandom_range(99) < 20);
      if (bufLoad) begin
        bufAddr = $urandom();
        bufLen  = LEN_W'($urandom_range(1, 3000));
        bufEop  = $urandom_range(1);
      end
      qRelease = 1'b0;
      if (mFree < QBYTES && $urandom_range(99) < 25) begin
        qRelease  = 1'b1;
        qRelBytes = CNT_W'($urandom_range(1, int'(QBYTES - mFree)));
      end
      reqDone = ($urandom_range(99) < 40);
      tick();
    end
    clearPulses();
    tick();

    finished = 1'b1;
    summary();
    $finish;
  end

endmodule